// File: doc/BRIEF.md
# Descriptor Ring Fetch Engine

This block is one DMA pipe that works through a circular ring of 8-byte descriptors held in system memory. Software programs a ring base address and a ring size in bytes. It then announces new work by writing the byte offset just past the last valid descriptor into a producer register. The engine keeps its own consumer offset. While the two offsets differ, it fetches the descriptor at the consumer offset and turns it into a transfer request on a simple request/acknowledge port. It then advances the consumer offset by 8 and wraps to zero at the ring size.

Descriptor reads and transfer requests each use a plain request/acknowledge handshake. The bus master that moves the data sits outside this block. Per-descriptor flags raise single-cycle pulses for interrupt, end of transfer and end of block when a descriptor completes. Software can pause the pipe, disable it, or hold it in a pipe-local reset through a register write. Software reads the live consumer offset to learn how far the engine has got. The engine cannot tell a full ring from an empty one, so software must always leave one slot unused.

Top module: `dring_pipe`

## Requirements
- R1: A descriptor is 64 bits wide. Bits [31:0] hold the buffer address, bits [47:32] the byte count and bits [63:48] the flags. For each descriptor with a non-zero count, `xfer_req` is raised with `xfer_addr` and `xfer_len` taken from the descriptor, and these stay stable until `xfer_ack`.
- R2: `desc_addr` equals the ring base plus the consumer offset. The low 3 bits of a written base are forced to zero, and the base reads back aligned.
- R3: Descriptors are processed in order from the consumer offset up to the producer offset. The consumer offset steps by 8 and becomes 0 when the step reaches the ring size. No fetch starts while the two offsets are equal.
- R4: Register map by word index: 0 control, 1 pipe reset, 2 halt, 3 base, 4 ring size, 5 producer, 6 consumer. A write to index 5 sets the producer offset from bits [15:0] with bits [2:0] dropped. Index 6 returns the consumer offset in bits [15:0].
- R5: A descriptor whose byte count is zero raises no transfer request but still completes and advances the consumer offset.
- R6: Completion is signalled in the cycle after the final acknowledge of a descriptor: the descriptor-read acknowledge for a zero count, otherwise the transfer acknowledge. `desc_done` pulses for one cycle. At the same time `irq_pulse` follows flag bit 15, `eot_pulse` follows flag bit 14 and `eob_pulse` follows flag bit 13.
- R7: Control bit 1 enables the pipe, and while it is clear no descriptor is fetched. Control bit 3 drives `xfer_dir` (1 = peripheral to memory).
- R8: Writing 1 to the halt register stops new descriptor fetches at a descriptor boundary, and writing 0 resumes them.
- R9: While the pipe reset register holds 1, control, halt, base, size, producer and consumer are all zero, writes to other registers are ignored and no request is raised. After 0 is written, the pipe is idle.
- R10: After `rst_n` is released, all registers read zero and no request is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| desc_req | output | 1 | Descriptor read request |
| desc_addr | output | 32 | Descriptor byte address |
| desc_ack | input | 1 | Descriptor read acknowledge, data valid |
| desc_data | input | 64 | Descriptor contents |
| xfer_req | output | 1 | Transfer request |
| xfer_addr | output | 32 | Transfer buffer address |
| xfer_len | output | 16 | Transfer byte count |
| xfer_dir | output | 1 | Transfer direction, 1 = peripheral to memory |
| xfer_ack | input | 1 | Transfer acknowledge |
| desc_done | output | 1 | Descriptor completed pulse |
| irq_pulse | output | 1 | Completion of a descriptor flagged for interrupt |
| eot_pulse | output | 1 | Completion of an end-of-transfer descriptor |
| eob_pulse | output | 1 | Completion of an end-of-block descriptor |

## Verification
The bench builds the pipe with its default parameters: 32-bit addresses and 16-bit offsets. It programs a 64-byte ring of eight slots, so that the random batches cross the wrap point many times and the one-empty-slot rule is met with batches of up to seven descriptors. The 16-bit offset width keeps the offset comparison and the step-past-size wrap at their full width, and a small ring size still exercises them often.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int DESC_BYTES   = 8;
  localparam int FLAG_INT_BIT = 15;
  localparam int FLAG_EOT_BIT = 14;
  localparam int FLAG_EOB_BIT = 13;
  localparam int CTRL_EN_BIT  = 1;
  localparam int CTRL_DIR_BIT = 3;

  localparam logic [2:0] RIDX_CTRL  = 3'd0;
  localparam logic [2:0] RIDX_RST   = 3'd1;
  localparam logic [2:0] RIDX_HALT  = 3'd2;
  localparam logic [2:0] RIDX_BASE  = 3'd3;
  localparam logic [2:0] RIDX_SIZE  = 3'd4;
  localparam logic [2:0] RIDX_PROD  = 3'd5;
  localparam logic [2:0] RIDX_CONS  = 3'd6;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_XFER, ST_DONE} pipe_state_e;
endpackage

// File: rtl/dring_regs.sv
module dring_regs
  import dring_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [OW-1:0] cons_ofs,
  output logic [DW-1:0] rdata,
  output logic          enable,
  output logic          dir,
  output logic          halt,
  output logic [AW-1:0] base,
  output logic [OW-1:0] size,
  output logic [OW-1:0] prod,
  output logic          soft_clr
);
  logic          en_q, en_d, dir_q, dir_d, rst_q, rst_d, halt_q, halt_d;
  logic [AW-1:0] base_q, base_d;
  logic [OW-1:0] size_q, size_d, prod_q, prod_d;

  always_comb begin
    en_d   = en_q;
    dir_d  = dir_q;
    rst_d  = rst_q;
    halt_d = halt_q;
    base_d = base_q;
    size_d = size_q;
    prod_d = prod_q;
    if (rst_q) begin
      en_d   = 1'b0;
      dir_d  = 1'b0;
      halt_d = 1'b0;
      base_d = '0;
      size_d = '0;
      prod_d = '0;
      if (wr_en && addr == RIDX_RST) rst_d = wdata[0];
    end else if (wr_en) begin
      unique case (addr)
        RIDX_CTRL: begin
          en_d  = wdata[CTRL_EN_BIT];
          dir_d = wdata[CTRL_DIR_BIT];
        end
        RIDX_RST:  rst_d  = wdata[0];
        RIDX_HALT: halt_d = wdata[0];
        RIDX_BASE: base_d = {wdata[AW-1:3], 3'b000};
        RIDX_SIZE: size_d = {wdata[OW-1:3], 3'b000};
        RIDX_PROD: prod_d = {wdata[OW-1:3], 3'b000};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
      rst_q  <= 1'b0;
      halt_q <= 1'b0;
      base_q <= '0;
      size_q <= '0;
      prod_q <= '0;
    end else begin
      en_q   <= en_d;
      dir_q  <= dir_d;
      rst_q  <= rst_d;
      halt_q <= halt_d;
      base_q <= base_d;
      size_q <= size_d;
      prod_q <= prod_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      RIDX_CTRL: begin
        rdata[CTRL_EN_BIT]  = en_q;
        rdata[CTRL_DIR_BIT] = dir_q;
      end
      RIDX_RST:  rdata[0] = rst_q;
      RIDX_HALT: rdata[0] = halt_q;
      RIDX_BASE: rdata = DW'(base_q);
      RIDX_SIZE: rdata = DW'(size_q);
      RIDX_PROD: rdata = DW'(prod_q);
      RIDX_CONS: rdata = DW'(cons_ofs);
      default:   rdata = '0;
    endcase
  end

  assign enable   = en_q;
  assign dir      = dir_q;
  assign halt     = halt_q;
  assign base     = base_q;
  assign size     = size_q;
  assign prod     = prod_q;
  assign soft_clr = rst_q;

  // R9: while the pipe is held in reset, a write to another register changes nothing
  a_r9_regs_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q && rst_d) |=> (base_q == '0 && prod_q == '0 && !en_q && !halt_q));
endmodule

// File: rtl/dring_ptr.sv
module dring_ptr
  import dring_pkg::*;
#(
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          advance,
  input  logic [OW-1:0] size,
  output logic [OW-1:0] cons
);
  logic [OW-1:0] cons_q, cons_d;
  logic [OW:0]   stepped;

  assign stepped = {1'b0, cons_q} + (OW+1)'(DESC_BYTES);

  always_comb begin
    cons_d = cons_q;
    if (clr)
      cons_d = '0;
    else if (advance)
      cons_d = (stepped >= {1'b0, size}) ? '0 : stepped[OW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cons_q <= '0;
    else        cons_q <= cons_d;
  end

  assign cons = cons_q;

  // R3: each completion either steps by one descriptor or wraps to zero
  a_r3_step_or_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clr) |=> (cons_q == '0 || cons_q == $past(cons_q) + OW'(DESC_BYTES)));
  // R3: offsets stay descriptor aligned
  a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    cons_q[2:0] == 3'b000);
endmodule

// File: rtl/dring_fsm.sv
module dring_fsm
  import dring_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] cons,
  output logic          desc_req,
  output logic [AW-1:0] desc_addr,
  input  logic          desc_ack,
  input  logic [63:0]   desc_data,
  output logic          xfer_req,
  output logic [AW-1:0] xfer_addr,
  output logic [LW-1:0] xfer_len,
  input  logic          xfer_ack,
  output logic          done,
  output logic          irq,
  output logic          eot,
  output logic          eob
);
  pipe_state_e   state_q, state_d;
  logic          capture;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_q;
  logic [15:0]   flags_q;
  logic [LW-1:0] fetched_len;

  assign fetched_len = desc_data[32 +: LW];

  always_comb begin
    state_d = state_q;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_FETCH;
      ST_FETCH: if (desc_ack) begin
        capture = 1'b1;
        state_d = (fetched_len == '0) ? ST_DONE : ST_XFER;
      end
      ST_XFER:  if (xfer_ack) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    if (clr) begin
      state_d = ST_IDLE;
      capture = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      len_q   <= '0;
      flags_q <= '0;
    end else if (capture) begin
      addr_q  <= desc_data[AW-1:0];
      len_q   <= fetched_len;
      flags_q <= desc_data[63:48];
    end
  end

  assign desc_req  = (state_q == ST_FETCH);
  assign desc_addr = base + AW'(cons);
  assign xfer_req  = (state_q == ST_XFER);
  assign xfer_addr = addr_q;
  assign xfer_len  = len_q;
  assign done      = (state_q == ST_DONE);
  assign irq       = done && flags_q[FLAG_INT_BIT];
  assign eot       = done && flags_q[FLAG_EOT_BIT];
  assign eob       = done && flags_q[FLAG_EOB_BIT];

  // R6: completion only in the cycle after a closing acknowledge
  a_r6_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past((xfer_req && xfer_ack) || (desc_req && desc_ack)));
  // R5: never a transfer request for an empty descriptor
  a_r5_no_empty_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (xfer_len != '0));
  // R1: request fields hold until acknowledged
  a_r1_xfer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack && !clr) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_len)));
endmodule

// File: rtl/dring_pipe.sv
module dring_pipe
  import dring_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int LW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          desc_req,
  output logic [AW-1:0] desc_addr,
  input  logic          desc_ack,
  input  logic [63:0]   desc_data,
  output logic          xfer_req,
  output logic [AW-1:0] xfer_addr,
  output logic [LW-1:0] xfer_len,
  output logic          xfer_dir,
  input  logic          xfer_ack,
  output logic          desc_done,
  output logic          irq_pulse,
  output logic          eot_pulse,
  output logic          eob_pulse
);
  logic          enable, halt, soft_clr, start;
  logic [AW-1:0] base;
  logic [OW-1:0] size, prod, cons;

  dring_regs #(.AW(AW), .OW(OW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cons_ofs(cons), .rdata(reg_rdata), .enable(enable), .dir(xfer_dir), .halt(halt),
    .base(base), .size(size), .prod(prod), .soft_clr(soft_clr)
  );

  dring_ptr #(.OW(OW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .advance(desc_done),
    .size(size), .cons(cons)
  );

  assign start = enable && !halt && !soft_clr && (cons != prod);

  dring_fsm #(.AW(AW), .OW(OW), .LW(LW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .start(start), .base(base), .cons(cons),
    .desc_req(desc_req), .desc_addr(desc_addr), .desc_ack(desc_ack), .desc_data(desc_data),
    .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_ack(xfer_ack),
    .done(desc_done), .irq(irq_pulse), .eot(eot_pulse), .eob(eob_pulse)
  );

  // R8: a halted idle pipe starts no fetch
  a_r8_halt_blocks_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !desc_req && !xfer_req && !desc_done) |=> !desc_req);
  // R7: a disabled idle pipe starts no fetch
  a_r7_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !desc_req && !xfer_req && !desc_done) |=> !desc_req);
  // R3: equal offsets keep the idle pipe idle
  a_r3_idle_when_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (cons == prod && !desc_req && !xfer_req && !desc_done) |=> !desc_req);
  // R9: pipe reset clears the consumer offset and all requests
  a_r9_pipe_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (cons == '0 && !desc_req && !xfer_req));
endmodule

// File: tb/dring_pipe_bench.sv
`timescale 1ns/1ps
module dring_pipe_bench;
  localparam logic [31:0] BASE_WR  = 32'h1000_0107;
  localparam logic [31:0] BASE_EXP = 32'h1000_0100;
  localparam int          RING     = 64;
  localparam int          SLOTS    = RING / 8;

  logic        clk, rst_n, reg_wr, desc_req, desc_ack, xfer_req, xfer_dir, xfer_ack;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, desc_addr, xfer_addr;
  logic [63:0] desc_data;
  logic [15:0] xfer_len;
  logic        desc_done, irq_pulse, eot_pulse, eob_pulse;

  dring_pipe u_dring_pipe (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .desc_req(desc_req), .desc_addr(desc_addr), .desc_ack(desc_ack),
    .desc_data(desc_data), .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_dir(xfer_dir), .xfer_ack(xfer_ack), .desc_done(desc_done), .irq_pulse(irq_pulse),
    .eot_pulse(eot_pulse), .eob_pulse(eob_pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [63:0] mem [SLOTS];
  logic [31:0] got_addr [256];
  logic [15:0] got_len  [256];
  logic        got_dir  [256];
  int got_n = 0, n_fetch = 0, n_done = 0, n_irq = 0, n_eot = 0, n_eob = 0;
  int ddly = 0, xdly = 0;
  int cons_m = 0;
  logic dir_m = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  // responders and pulse monitor, all on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      // R6: completion appears the cycle after an acknowledge
      if (desc_done) chk(desc_ack || xfer_ack, "R6 done after ack", 32'(desc_done), 32'(1));
      if (desc_done) n_done++;
      if (irq_pulse) n_irq++;
      if (eot_pulse) n_eot++;
      if (eob_pulse) n_eob++;
    end
    if (desc_ack) desc_ack = 1'b0;
    else if (desc_req) begin
      if (ddly == 0) begin
        // R2: fetch address inside the aligned ring
        chk(desc_addr[2:0] == 3'b000 && desc_addr - BASE_EXP < RING, "R2 fetch address",
            desc_addr, BASE_EXP);
        desc_data = mem[(desc_addr - BASE_EXP) >> 3];
        desc_ack  = 1'b1;
        n_fetch++;
        ddly = int'($urandom % 3);
      end else ddly--;
    end
    if (xfer_ack) xfer_ack = 1'b0;
    else if (xfer_req) begin
      if (xdly == 0) begin
        got_addr[got_n % 256] = xfer_addr;
        got_len[got_n % 256]  = xfer_len;
        got_dir[got_n % 256]  = xfer_dir;
        got_n++;
        xfer_ack = 1'b1;
        xdly = int'($urandom % 4);
      end else xdly--;
    end
  end

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_addr = idx;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(input int prod);
    logic [31:0] c;
    for (int i = 0; i < 400; i++) begin
      rd(3'd6, c);
      if (c == 32'(prod)) break;
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [63:0] make_desc(input bit force_zero);
    logic [15:0] len;
    logic [15:0] flg;
    len = (force_zero || ($urandom % 5 == 0)) ? 16'd0 : 16'(($urandom % 4096) + 1);
    flg = {3'($urandom), 13'd0};
    return {flg, len, $urandom};
  endfunction

  // one batch of k descriptors starting at the model consumer offset
  task automatic batch(input int k, input bit zero_first);
    logic [31:0] ea [8];
    logic [15:0] el [8];
    int en = 0, ei = 0, et = 0, eb = 0;
    int g0, f0, d0, i0, t0, b0, prod;
    logic [31:0] c;
    for (int i = 0; i < k; i++) begin
      int s = ((cons_m / 8) + i) % SLOTS;
      mem[s] = make_desc(zero_first && i == 0);
      if (mem[s][47:32] != 16'd0) begin
        ea[en] = mem[s][31:0]; el[en] = mem[s][47:32]; en++;
      end
      ei += int'(mem[s][63]); et += int'(mem[s][62]); eb += int'(mem[s][61]);
    end
    g0 = got_n; f0 = n_fetch; d0 = n_done; i0 = n_irq; t0 = n_eot; b0 = n_eob;
    prod = (cons_m + 8 * k) % RING;
    wr(3'd5, 32'(prod));
    wait_idle(prod);
    rd(3'd6, c);
    chk(c == 32'(prod), "R3 consumer reaches producer", c, 32'(prod));
    chk(got_n - g0 == en, "R5 transfer count skips empty", 32'(got_n - g0), 32'(en));
    for (int i = 0; i < en && i < got_n - g0; i++) begin
      chk(got_addr[(g0 + i) % 256] == ea[i], "R1 transfer address", got_addr[(g0 + i) % 256], ea[i]);
      chk(got_len[(g0 + i) % 256] == el[i], "R1 transfer length", 32'(got_len[(g0 + i) % 256]), 32'(el[i]));
      chk(got_dir[(g0 + i) % 256] == dir_m, "R7 direction", 32'(got_dir[(g0 + i) % 256]), 32'(dir_m));
    end
    chk(n_fetch - f0 == k, "R3 fetch count", 32'(n_fetch - f0), 32'(k));
    chk(n_done - d0 == k, "R6 done count", 32'(n_done - d0), 32'(k));
    chk(n_irq - i0 == ei, "R6 irq count", 32'(n_irq - i0), 32'(ei));
    chk(n_eot - t0 == et, "R6 eot count", 32'(n_eot - t0), 32'(et));
    chk(n_eob - b0 == eb, "R6 eob count", 32'(n_eob - b0), 32'(eb));
    cons_m = prod;
  endtask

  initial begin
    logic [31:0] v;
    int f0, prod;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    desc_ack = 1'b0; xfer_ack = 1'b0; desc_data = '0;
    for (int i = 0; i < SLOTS; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!desc_req && !xfer_req, "R10 no request after reset", 32'({desc_req, xfer_req}), 0);
    rd(3'd6, v); chk(v == 0, "R10 consumer after reset", v, 0);
    rd(3'd0, v); chk(v == 0, "R10 control after reset", v, 0);

    wr(3'd3, BASE_WR);
    rd(3'd3, v); chk(v == BASE_EXP, "R2 base aligned", v, BASE_EXP);
    wr(3'd4, RING);
    wr(3'd0, 32'h2);
    dir_m = 1'b0;

    batch(3, 1'b1);
    batch(7, 1'b0);
    wr(3'd0, 32'hA); dir_m = 1'b1;
    for (int b = 0; b < 10; b++) batch(int'($urandom % 7) + 1, b == 4);
    // R4 producer low bits dropped
    wr(3'd5, 32'(cons_m + 8 + 5));
    rd(3'd5, v); chk(v == 32'(cons_m + 8), "R4 producer alignment", v, 32'(cons_m + 8));
    wait_idle(cons_m + 8);
    cons_m = (cons_m + 8) % RING;

    // R7 disabled pipe ignores new work
    wr(3'd0, 32'h0);
    f0 = n_fetch;
    prod = (cons_m + 16) % RING;
    mem[cons_m / 8] = make_desc(1'b0); mem[((cons_m / 8) + 1) % SLOTS] = make_desc(1'b0);
    wr(3'd5, 32'(prod));
    repeat (20) @(negedge clk);
    chk(n_fetch == f0, "R7 no fetch while disabled", 32'(n_fetch - f0), 0);
    rd(3'd6, v); chk(v == 32'(cons_m), "R7 consumer held while disabled", v, 32'(cons_m));
    wr(3'd0, 32'h2); dir_m = 1'b0;
    wait_idle(prod);
    chk(n_fetch - f0 == 2, "R7 resumes when enabled", 32'(n_fetch - f0), 2);
    cons_m = prod;

    // R8 halt
    wr(3'd2, 32'h1);
    f0 = n_fetch;
    batch_halt: begin
      prod = (cons_m + 24) % RING;
      for (int i = 0; i < 3; i++) mem[((cons_m / 8) + i) % SLOTS] = make_desc(1'b0);
      wr(3'd5, 32'(prod));
      repeat (20) @(negedge clk);
      chk(n_fetch == f0, "R8 no fetch while halted", 32'(n_fetch - f0), 0);
      rd(3'd6, v); chk(v == 32'(cons_m), "R8 consumer held while halted", v, 32'(cons_m));
      wr(3'd2, 32'h0);
      wait_idle(prod);
      chk(n_fetch - f0 == 3, "R8 resumes after release", 32'(n_fetch - f0), 3);
      cons_m = prod;
    end
    batch(5, 1'b0);

    // R9 pipe reset
    wr(3'd1, 32'h1);
    wr(3'd3, 32'h2000_0000);
    rd(3'd3, v); chk(v == 0, "R9 base cleared and write ignored", v, 0);
    wr(3'd1, 32'h0);
    rd(3'd0, v); chk(v == 0, "R9 control cleared", v, 0);
    rd(3'd4, v); chk(v == 0, "R9 size cleared", v, 0);
    rd(3'd5, v); chk(v == 0, "R9 producer cleared", v, 0);
    rd(3'd6, v); chk(v == 0, "R9 consumer cleared", v, 0);
    chk(!desc_req && !xfer_req, "R9 idle after reset", 32'({desc_req, xfer_req}), 0);

    // reprogram and run again from slot zero
    cons_m = 0;
    wr(3'd3, BASE_WR); wr(3'd4, RING); wr(3'd0, 32'h2); dir_m = 1'b0;
    batch(6, 1'b0);
    batch(7, 1'b1);
    finish_run();
  end
endmodule